// File: doc/BRIEF.md
# Store-to-Load Forwarding Search Unit

This block keeps a small circular queue of in-flight stores and answers load lookups against it. Each slot holds a store's address, sequence number, uncacheable flag, byte size and up to eight bytes of data. Slot contents arrive in two steps. A define port claims a slot and leaves it empty. A data port later fills in the slot's size and bytes.

A load lookup presents the load's address, size, sequence number and queue position. The block then walks the store queue from the load's position back to the writeback pointer. It returns one of four result codes one cycle later: forwarded data, a stall for a partial overlap, a fault for an uncacheable load issued too early, or a plain memory access. Two records sit next to the result path. One holds the oldest load stalled on a partial overlap. The other holds the oldest load that met a blocked cache. A clear input releases both records.

Top module: `sfwd_unit`

## Requirements
- R1: After reset there is no result, nothing is stalled or blocked, and every slot is empty, so any lookup returns the memory code.
- R2: `lkReady` equals the inverse of `clear`. An accepted lookup (`lkValid && lkReady`) raises `resValid` for exactly one cycle on the following cycle. With no accepted lookup, `resValid` stays low.
- R3: The walk skips entirely when `lkNoStore` is 1. Otherwise it examines slots `lkStIdx-1`, `lkStIdx-2`, … down to and including `wbPtr`, wrapping from 0 to the last slot. It examines nothing when `lkStIdx == wbPtr`. The first (youngest) slot that overlaps the load decides the result.
- R4: The walk passes over a slot of size 0 or a slot marked uncacheable.
- R5: If the load's bytes lie wholly inside a slot's bytes, the result code is 2'b01 (forward). The data is the slot's bytes starting at offset `lkAddr & (size-1)`, placed at byte 0, with every byte at or above the load size set to zero.
- R6: If the load and a slot intersect without containment, the result code is 2'b10 (stall) and the data is zero. When no slot overlaps, the result code is 2'b00 (memory).
- R7: A stall result records the load index, the load sequence number and the conflicting store's sequence number. It does so only when no stall is held or when the new load's sequence number is smaller than the held one.
- R8: An uncacheable load that is not both at the load-queue head and ready to commit returns code 2'b11 (fault) with zero data, and it changes neither record.
- R9: A memory result while `cacheBlocked` is 1 sets the blocked record with the load's sequence number. A record already held is kept if its sequence number is smaller.
- R10: A define write sets a slot's address, sequence number and uncacheable flag and empties the slot (size 0). A data write sets the slot's size and its little-endian bytes, so byte k of `wrData` holds the byte at address+k.
- R11: While `clear` is 1, no lookup is accepted, and on the next cycle neither record is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Releases the stall and blocked records; holds off lookups |
| defValid | input | 1 | Define a slot |
| defIdx | input | IDX_W | Slot being defined |
| defAddr | input | ADDR_W | Store address |
| defSeq | input | SEQ_W | Store sequence number |
| defUncache | input | 1 | Store is uncacheable |
| wrValid | input | 1 | Write store data |
| wrIdx | input | IDX_W | Slot being written |
| wrSize | input | 4 | Store width in bytes (1, 2, 4 or 8) |
| wrData | input | 64 | Store data, byte 0 at the store address |
| wbPtr | input | IDX_W | Writeback pointer, oldest slot searched |
| lkValid | input | 1 | Lookup request |
| lkReady | output | 1 | Lookup can be accepted |
| lkLoadIdx | input | LIDX_W | Load-queue index of the load |
| lkAddr | input | ADDR_W | Load address |
| lkSize | input | 4 | Load width in bytes (1, 2, 4 or 8) |
| lkSeq | input | SEQ_W | Load sequence number (smaller is older) |
| lkStIdx | input | IDX_W | Slot just past the load's youngest older store |
| lkNoStore | input | 1 | Load has no older store; skip the walk |
| lkUncache | input | 1 | Load is uncacheable |
| lkAtHead | input | 1 | Load is at the load-queue head |
| lkAtCommit | input | 1 | Load is ready to commit |
| cacheBlocked | input | 1 | Cache cannot take an access this cycle |
| resValid | output | 1 | Result valid |
| resCode | output | 2 | 00 memory, 01 forward, 10 stall, 11 fault |
| resData | output | 64 | Forwarded data at byte 0 |
| stalled | output | 1 | A stall record is held |
| stallLoadIdx | output | LIDX_W | Load index of the stalled load |
| stallLoadSeq | output | SEQ_W | Sequence number of the stalled load |
| stallStoreSeq | output | SEQ_W | Sequence number of the conflicting store |
| blocked | output | 1 | A blocked-load record is held |
| blockedSeq | output | SEQ_W | Sequence number of the blocked load |

## Verification
Some rules are checked by assertions on every cycle. A result always follows an accepted lookup after exactly one cycle, and never appears otherwise. Clear always empties both records. Non-forward results always carry zero data. A held record is replaced only by an older load. A record rises only together with a matching stall or memory result.

Other behaviour is shown only by the bench's scenarios, compared against its behavioural queue model:
- the search order, including the wrap past slot 0;
- which slot wins when several overlap;
- skipped empty and uncacheable slots;
- the byte offset of forwarded data;
- the fault gating of uncacheable loads.

// File: rtl/sfwd_pkg.sv
package sfwd_pkg;
  localparam int DATA_BYTES = 8;
  localparam int DATA_W     = DATA_BYTES * 8;
  localparam int SZ_W       = $clog2(DATA_BYTES) + 1;
  localparam int OFF_W      = $clog2(DATA_BYTES);

  typedef enum logic [1:0] {
    RES_MEM   = 2'b00,
    RES_FWD   = 2'b01,
    RES_STALL = 2'b10,
    RES_FAULT = 2'b11
  } resCode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic     loadRes;
    resCode_e code;
  } ctlStrobe_t;
endpackage

// File: rtl/sfwd_datapath.sv
module sfwd_datapath
  import sfwd_pkg::*;
#(
  parameter int NSLOT  = 8,
  parameter int ADDR_W = 16,
  parameter int SEQ_W  = 8,
  localparam int IDX_W = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              defValid,
  input  logic [IDX_W-1:0]  defIdx,
  input  logic [ADDR_W-1:0] defAddr,
  input  logic [SEQ_W-1:0]  defSeq,
  input  logic              defUncache,
  input  logic              wrValid,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [SZ_W-1:0]   wrSize,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  wbPtr,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic [SZ_W-1:0]   lkSize,
  input  logic [IDX_W-1:0]  lkStIdx,
  input  logic              lkNoStore,
  input  ctlStrobe_t        strobe,
  output logic              hitFull,
  output logic              hitPart,
  output logic [SEQ_W-1:0]  conflictSeq,
  output logic              resValid,
  output resCode_e          resCode,
  output logic [DATA_W-1:0] resData
);
  localparam int EXT_W = ADDR_W + 1;

  logic [ADDR_W-1:0] slotAddr [NSLOT];
  logic [SEQ_W-1:0]  slotSeq  [NSLOT];
  logic              slotUnc  [NSLOT];
  logic [SZ_W-1:0]   slotSize [NSLOT];
  logic [DATA_W-1:0] slotData [NSLOT];

  logic [NSLOT-1:0] eligible, contains, touches;

  // storage: define empties a slot, data write fills size and bytes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NSLOT; i++) slotSize[i] <= '0;
    end else begin
      if (defValid) begin
        slotAddr[defIdx] <= defAddr;
        slotSeq[defIdx]  <= defSeq;
        slotUnc[defIdx]  <= defUncache;
        slotSize[defIdx] <= '0;
      end
      if (wrValid) begin
        slotSize[wrIdx] <= wrSize;
        slotData[wrIdx] <= wrData;
      end
    end
  end

  // per-slot range comparison
  logic [EXT_W-1:0] ldLo, ldHi;
  assign ldLo = {1'b0, lkAddr};
  assign ldHi = ldLo + EXT_W'(lkSize);

  for (genvar g = 0; g < NSLOT; g++) begin : g_cmp
    logic [EXT_W-1:0] stLo, stHi;
    assign stLo = {1'b0, slotAddr[g]};
    assign stHi = stLo + EXT_W'(slotSize[g]);
    assign eligible[g] = (slotSize[g] != '0) && !slotUnc[g];
    assign contains[g] = (ldLo >= stLo) && (ldHi <= stHi);
    assign touches[g]  = (ldLo < stHi) && (ldHi > stLo);
  end

  // backward walk from the load's position to the writeback pointer
  logic [IDX_W-1:0] selIdx;
  always_comb begin
    logic [IDX_W-1:0] pos;
    logic             done;
    pos     = lkStIdx;
    done    = lkNoStore;
    hitFull = 1'b0;
    hitPart = 1'b0;
    selIdx  = '0;
    for (int k = 0; k < NSLOT; k++) begin
      if (!done) begin
        if (pos == wbPtr) begin
          done = 1'b1;
        end else begin
          pos = (pos == '0) ? IDX_W'(NSLOT - 1) : pos - 1'b1;
          if (eligible[pos] && touches[pos]) begin
            done    = 1'b1;
            selIdx  = pos;
            hitFull = contains[pos];
            hitPart = !contains[pos];
          end
        end
      end
    end
  end

  assign conflictSeq = slotSeq[selIdx];

  function automatic logic [DATA_W-1:0] alignBytes(
    input logic [DATA_W-1:0] raw, input logic [OFF_W-1:0] off,
    input logic [SZ_W-1:0] nBytes);
    logic [DATA_W-1:0] s;
    s = raw >> {off, 3'b000};
    for (int b = 0; b < DATA_BYTES; b++)
      if (b >= int'(nBytes)) s[b*8 +: 8] = 8'h00;
    return s;
  endfunction

  logic [OFF_W-1:0]  fwdOff;
  logic [DATA_W-1:0] fwdData;
  assign fwdOff  = lkAddr[OFF_W-1:0] & OFF_W'(slotSize[selIdx] - 1'b1);
  assign fwdData = alignBytes(slotData[selIdx], fwdOff, lkSize);

  // one-cycle result register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resCode  <= RES_MEM;
      resData  <= '0;
    end else begin
      resValid <= strobe.loadRes;
      if (strobe.loadRes) begin
        resCode <= strobe.code;
        resData <= (strobe.code == RES_FWD) ? fwdData : '0;
      end
    end
  end
endmodule

// File: rtl/sfwd_control.sv
module sfwd_control
  import sfwd_pkg::*;
#(
  parameter int SEQ_W  = 8,
  parameter int LIDX_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic              lkValid,
  output logic              lkReady,
  input  logic [LIDX_W-1:0] lkLoadIdx,
  input  logic [SEQ_W-1:0]  lkSeq,
  input  logic              lkUncache,
  input  logic              lkAtHead,
  input  logic              lkAtCommit,
  input  logic              cacheBlocked,
  input  logic              hitFull,
  input  logic              hitPart,
  input  logic [SEQ_W-1:0]  conflictSeq,
  output ctlStrobe_t        strobe,
  output logic              stalled,
  output logic [LIDX_W-1:0] stallLoadIdx,
  output logic [SEQ_W-1:0]  stallLoadSeq,
  output logic [SEQ_W-1:0]  stallStoreSeq,
  output logic              blocked,
  output logic [SEQ_W-1:0]  blockedSeq
);
  logic     accept, earlyUnc;
  resCode_e code;

  assign lkReady  = !clear;
  assign accept   = lkValid && lkReady;
  assign earlyUnc = lkUncache && !(lkAtHead && lkAtCommit);

  always_comb begin
    if (earlyUnc)     code = RES_FAULT;
    else if (hitFull) code = RES_FWD;
    else if (hitPart) code = RES_STALL;
    else              code = RES_MEM;
  end

  assign strobe.loadRes = accept;
  assign strobe.code    = code;

  logic takeStall, takeBlock;
  assign takeStall = accept && (code == RES_STALL) &&
                     (!stalled || (lkSeq < stallLoadSeq));
  assign takeBlock = accept && (code == RES_MEM) && cacheBlocked &&
                     (!blocked || !(blockedSeq < lkSeq));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stalled       <= 1'b0;
      stallLoadIdx  <= '0;
      stallLoadSeq  <= '0;
      stallStoreSeq <= '0;
      blocked       <= 1'b0;
      blockedSeq    <= '0;
    end else if (clear) begin
      stalled <= 1'b0;
      blocked <= 1'b0;
    end else begin
      if (takeStall) begin
        stalled       <= 1'b1;
        stallLoadIdx  <= lkLoadIdx;
        stallLoadSeq  <= lkSeq;
        stallStoreSeq <= conflictSeq;
      end
      if (takeBlock) begin
        blocked    <= 1'b1;
        blockedSeq <= lkSeq;
      end
    end
  end
endmodule

// File: rtl/sfwd_unit.sv
module sfwd_unit
  import sfwd_pkg::*;
#(
  parameter int NSLOT  = 8,
  parameter int ADDR_W = 16,
  parameter int SEQ_W  = 8,
  parameter int LIDX_W = 4,
  localparam int IDX_W = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic              defValid,
  input  logic [IDX_W-1:0]  defIdx,
  input  logic [ADDR_W-1:0] defAddr,
  input  logic [SEQ_W-1:0]  defSeq,
  input  logic              defUncache,
  input  logic              wrValid,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [3:0]        wrSize,
  input  logic [63:0]       wrData,
  input  logic [IDX_W-1:0]  wbPtr,
  input  logic              lkValid,
  output logic              lkReady,
  input  logic [LIDX_W-1:0] lkLoadIdx,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic [3:0]        lkSize,
  input  logic [SEQ_W-1:0]  lkSeq,
  input  logic [IDX_W-1:0]  lkStIdx,
  input  logic              lkNoStore,
  input  logic              lkUncache,
  input  logic              lkAtHead,
  input  logic              lkAtCommit,
  input  logic              cacheBlocked,
  output logic              resValid,
  output logic [1:0]        resCode,
  output logic [63:0]       resData,
  output logic              stalled,
  output logic [LIDX_W-1:0] stallLoadIdx,
  output logic [SEQ_W-1:0]  stallLoadSeq,
  output logic [SEQ_W-1:0]  stallStoreSeq,
  output logic              blocked,
  output logic [SEQ_W-1:0]  blockedSeq
);
  ctlStrobe_t       strobe;
  logic             hitFull, hitPart;
  logic [SEQ_W-1:0] conflictSeq;
  resCode_e         resCodeE;

  sfwd_datapath #(.NSLOT(NSLOT), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W)) u_dp (
    .clk, .rstN, .defValid, .defIdx, .defAddr, .defSeq, .defUncache,
    .wrValid, .wrIdx, .wrSize, .wrData, .wbPtr, .lkAddr, .lkSize,
    .lkStIdx, .lkNoStore, .strobe, .hitFull, .hitPart, .conflictSeq,
    .resValid, .resCode(resCodeE), .resData
  );

  sfwd_control #(.SEQ_W(SEQ_W), .LIDX_W(LIDX_W)) u_ctl (
    .clk, .rstN, .clear, .lkValid, .lkReady, .lkLoadIdx, .lkSeq,
    .lkUncache, .lkAtHead, .lkAtCommit, .cacheBlocked, .hitFull,
    .hitPart, .conflictSeq, .strobe, .stalled, .stallLoadIdx,
    .stallLoadSeq, .stallStoreSeq, .blocked, .blockedSeq
  );

  assign resCode = resCodeE;
endmodule

// File: rtl/sfwd_unit_chk.sv
module sfwd_unit_chk #(
  parameter int SEQ_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             clear,
  input logic             lkValid,
  input logic             lkReady,
  input logic             resValid,
  input logic [1:0]       resCode,
  input logic [63:0]      resData,
  input logic             stalled,
  input logic [SEQ_W-1:0] stallLoadSeq,
  input logic             blocked,
  input logic [SEQ_W-1:0] blockedSeq
);
  AST_RESULT_AFTER_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && lkReady) |=> resValid); // R2
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    !(lkValid && lkReady) |=> !resValid); // R2
  AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (!stalled && !blocked)); // R11
  AST_STALL_ONLY_OLDER: assert property (@(posedge clk) disable iff (!rstN)
    (stalled && !clear) |=> (stalled && stallLoadSeq <= $past(stallLoadSeq))); // R7
  AST_BLOCK_ONLY_OLDER: assert property (@(posedge clk) disable iff (!rstN)
    (blocked && !clear) |=> (blocked && blockedSeq <= $past(blockedSeq))); // R9
  AST_STALL_WITH_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stalled) |-> (resValid && resCode == 2'b10)); // R7
  AST_BLOCK_WITH_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(blocked) |-> (resValid && resCode == 2'b00)); // R9
  AST_NONFWD_ZERO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resCode != 2'b01) |-> (resData == 64'd0)); // R6
endmodule

bind sfwd_unit sfwd_unit_chk #(.SEQ_W(SEQ_W)) u_chk (
  .clk, .rstN, .clear, .lkValid, .lkReady, .resValid, .resCode, .resData,
  .stalled, .stallLoadSeq, .blocked, .blockedSeq
);

// File: tb/sfwd_unit_tb.sv
module sfwd_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOT = 8;
  localparam int IDX_W = 3;
  localparam int ADDR_W = 16;
  localparam int SEQ_W = 8;
  localparam int LIDX_W = 4;

  logic clk = 0, rstN = 0, clear = 0;
  logic defValid = 0, defUncache = 0, wrValid = 0;
  logic [IDX_W-1:0] defIdx = 0, wrIdx = 0, wbPtr = 0, lkStIdx = 0;
  logic [ADDR_W-1:0] defAddr = 0, lkAddr = 0;
  logic [SEQ_W-1:0] defSeq = 0, lkSeq = 0;
  logic [3:0] wrSize = 0, lkSize = 0;
  logic [63:0] wrData = 0;
  logic lkValid = 0, lkNoStore = 0, lkUncache = 0, lkAtHead = 0, lkAtCommit = 0;
  logic cacheBlocked = 0;
  logic [LIDX_W-1:0] lkLoadIdx = 0;
  logic lkReady, resValid, stalled, blocked;
  logic [1:0] resCode;
  logic [63:0] resData;
  logic [LIDX_W-1:0] stallLoadIdx;
  logic [SEQ_W-1:0] stallLoadSeq, stallStoreSeq, blockedSeq;

  sfwd_unit #(.NSLOT(NSLOT), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W), .LIDX_W(LIDX_W)) u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  string curReq = "R1";
  bit finished = 0;

  task automatic check(string req, string what, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int mAddr[NSLOT], mSeq[NSLOT], mSize[NSLOT];
  bit mUnc[NSLOT];
  byte unsigned mByte[NSLOT][8];
  bit eResValid, eStalled, eBlocked;
  int eCode, eStallIdx, eStallLdSeq, eStallStSeq, eBlkSeq;
  longint unsigned eData;

  task automatic modelLookup(output int code, output longint unsigned data);
    int pos;
    code = 0; data = 0;
    if (lkUncache && !(lkAtHead && lkAtCommit)) begin code = 3; return; end
    if (lkNoStore) return;
    pos = lkStIdx;
    while (pos != wbPtr) begin
      int lo, hi, sLo, sHi;
      pos = (pos + NSLOT - 1) % NSLOT;
      if (mSize[pos] == 0 || mUnc[pos]) continue;
      lo = lkAddr; hi = lo + lkSize; sLo = mAddr[pos]; sHi = sLo + mSize[pos];
      if (hi <= sLo || lo >= sHi) continue;
      if (lo >= sLo && hi <= sHi) begin
        int off = lo % mSize[pos];
        code = 1;
        for (int b = 0; b < lkSize; b++)
          data |= longint'(mByte[pos][off + b]) << (8 * b);
      end else begin
        code = 2;
        eStallStSeq = (eStalled && !(lkSeq < eStallLdSeq)) ? eStallStSeq : mSeq[pos];
      end
      return;
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NSLOT; i++) mSize[i] = 0;
      eResValid = 0; eStalled = 0; eBlocked = 0;
    end else begin
      eResValid = 0;
      if (clear) begin
        eStalled = 0; eBlocked = 0;
      end else if (lkValid) begin
        int c; longint unsigned d;
        modelLookup(c, d);
        eResValid = 1; eCode = c; eData = d;
        if (c == 2 && (!eStalled || lkSeq < eStallLdSeq)) begin
          eStalled = 1; eStallIdx = lkLoadIdx; eStallLdSeq = lkSeq;
        end
        if (c == 0 && cacheBlocked && (!eBlocked || !(eBlkSeq < lkSeq))) begin
          eBlocked = 1; eBlkSeq = lkSeq;
        end
      end
      if (defValid) begin
        mAddr[defIdx] = defAddr; mSeq[defIdx] = defSeq;
        mUnc[defIdx] = defUncache; mSize[defIdx] = 0;
      end
      if (wrValid) begin
        mSize[wrIdx] = wrSize;
        for (int b = 0; b < 8; b++) mByte[wrIdx][b] = wrData[b*8 +: 8];
      end
    end
  end

  // compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R2", "resValid", resValid, eResValid);
      if (eResValid) begin
        check(curReq, "resCode", resCode, eCode);
        check(curReq, "resData", resData, eData);
      end
      check("R7", "stalled", stalled, eStalled);
      if (eStalled) begin
        check("R7", "stallLoadIdx", stallLoadIdx, eStallIdx);
        check("R7", "stallLoadSeq", stallLoadSeq, eStallLdSeq);
        check("R7", "stallStoreSeq", stallStoreSeq, eStallStSeq);
      end
      check("R9", "blocked", blocked, eBlocked);
      if (eBlocked) check("R9", "blockedSeq", blockedSeq, eBlkSeq);
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic defSlot(int idx, int addr, int seq, bit unc);
    defValid = 1; defIdx = idx; defAddr = addr; defSeq = seq; defUncache = unc;
    tick(); defValid = 0;
  endtask

  task automatic wrSlot(int idx, int size, longint unsigned data);
    wrValid = 1; wrIdx = idx; wrSize = size; wrData = data;
    tick(); wrValid = 0;
  endtask

  // lookup, then direct check of the hand-computed result
  task automatic look(string req, int addr, int size, int seq, int stIdx, int ldIdx,
                      int expCode, longint unsigned expData);
    curReq = req;
    lkValid = 1; lkAddr = addr; lkSize = size; lkSeq = seq; lkStIdx = stIdx;
    lkLoadIdx = ldIdx;
    tick(); lkValid = 0;
    check(req, "direct code", resCode, expCode);
    check(req, "direct data", resData, expData);
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1; errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rstN = 1;
    tick();
    check("R1", "reset resValid", resValid, 0);
    check("R1", "reset stalled", stalled, 0);
    check("R1", "reset blocked", blocked, 0);
    look("R1", 'h100, 2, 1, 3, 0, 0, 0);

    // fill: slot0 0x100/8B, slot1 0x200/4B, slot2 0x104/2B
    defSlot(0, 'h100, 10, 0); wrSlot(0, 8, 64'h8877665544332211);
    defSlot(1, 'h200, 11, 0); wrSlot(1, 4, 64'h00000000CAFEF00D);
    defSlot(2, 'h104, 12, 0); wrSlot(2, 2, 64'h000000000000BBAA);

    look("R3", 'h104, 2, 20, 3, 1, 1, 64'hBBAA);       // youngest wins
    look("R5", 'h105, 1, 20, 3, 1, 1, 64'hBB);         // offset within slot2
    look("R5", 'h104, 4, 20, 2, 1, 1, 64'h88776655);   // slot0 offset 4
    look("R5", 'h102, 2, 20, 1, 1, 1, 64'h4433);
    look("R3", 'h100, 2, 20, 0, 1, 0, 0);              // stIdx==wbPtr
    lkNoStore = 1;
    look("R3", 'h104, 2, 20, 3, 1, 0, 0);
    lkNoStore = 0;

    // partial overlaps and stall record
    look("R6", 'h104, 4, 50, 3, 5, 2, 0);
    check("R7", "stall idx", stallLoadIdx, 5);
    check("R7", "stall store seq", stallStoreSeq, 12);
    look("R7", 'h104, 4, 60, 3, 6, 2, 0);              // younger: kept
    check("R7", "stall seq kept", stallLoadSeq, 50);
    look("R7", 'h106, 4, 40, 3, 7, 2, 0);              // older: replaces
    check("R7", "stall seq replaced", stallLoadSeq, 40);
    check("R7", "stall store seq replaced", stallStoreSeq, 10);

    // skipped slots
    defSlot(3, 'h300, 13, 1); wrSlot(3, 4, 64'h11223344);
    look("R4", 'h300, 4, 20, 4, 1, 0, 0);
    defSlot(4, 'h400, 14, 0);
    look("R4", 'h400, 2, 20, 5, 1, 0, 0);
    wrSlot(4, 2, 64'h0000000000009988);
    look("R10", 'h400, 2, 20, 5, 1, 1, 64'h9988);

    // uncacheable loads
    lkUncache = 1; lkAtHead = 1; lkAtCommit = 0;
    look("R8", 'h104, 4, 30, 3, 2, 3, 0);
    check("R8", "stall seq untouched", stallLoadSeq, 40);
    lkAtCommit = 1;
    look("R8", 'h104, 2, 30, 3, 2, 1, 64'hBBAA);
    lkUncache = 0; lkAtHead = 0; lkAtCommit = 0;

    // blocked record
    cacheBlocked = 1;
    look("R9", 'h800, 8, 70, 3, 3, 0, 0);
    check("R9", "blocked seq", blockedSeq, 70);
    look("R9", 'h800, 8, 80, 3, 3, 0, 0);
    check("R9", "blocked kept", blockedSeq, 70);
    look("R9", 'h800, 8, 65, 3, 3, 0, 0);
    check("R9", "blocked replaced", blockedSeq, 65);
    cacheBlocked = 0;

    // clear
    curReq = "R11";
    clear = 1; lkValid = 1; lkAddr = 'h104; lkSize = 2; lkStIdx = 3;
    tick(); clear = 0; lkValid = 0;
    check("R11", "no accept in clear", resValid, 0);
    check("R11", "stall released", stalled, 0);
    check("R11", "blocked released", blocked, 0);

    // wrap-around walk
    wbPtr = 6;
    defSlot(6, 'h600, 20, 0); wrSlot(6, 8, 64'h0123456789ABCDEF);
    defSlot(7, 'h700, 21, 0); wrSlot(7, 4, 64'h55555555);
    defSlot(0, 'h500, 22, 0); wrSlot(0, 8, 64'h1);
    look("R3", 'h604, 2, 30, 1, 1, 1, 64'h4567);
    look("R3", 'h104, 2, 30, 1, 1, 0, 0);              // slot2 beyond wb
    look("R5", 'h500, 8, 30, 1, 1, 1, 64'h1);

    tick();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule